// File: doc/BRIEF.md
# SPI Controller Register and FIFO Front End

This block sits between a 32-bit register bus and a serial shift engine. Software programs the clock timing, chip-select timing and packet shape through a set of configuration registers. It writes outgoing data as whole words into one transmit data port and reads incoming data as whole words from one receive data port. Behind each port is a byte-wide FIFO. A transmit word is split into four bytes. Received bytes are gathered back into a word, and the order of the bytes inside that word can be selected for each direction.

A command register holds the clock mode, the bit-order and byte-order selects and the interrupt enables. Two of its bits are self-clearing strobes that start or resume the engine. A third bit holds the engine in reset and empties both FIFOs for as long as it stays set. The engine reports the end of each run with a one-cycle event that also says whether the run stopped in the paused state. This is recorded in a status register, and the recorded state drives a single interrupt line. Reading the status register clears it. The two address registers used for memory transfers are only stored and driven out.

The bus uses a word index, which is the byte offset divided by four. Bus read data is combinational on the index. The side effects of a read (FIFO pop, status clear) take place at the clock edge where `bus_rd` is high.

Top module: `spi_reg_front`

## Requirements
- R1: After reset every register reads zero, the interrupt, strobes and engine hold are low, and the transmit FIFO is empty.
- R2: Word index 0 holds four 8-bit timing fields: SCK high time in bits 7:0, SCK low time in bits 15:8, CS hold in bits 23:16 and CS setup in bits 31:24. Each field drives its own output, and the word reads back unchanged.
- R3: Word index 1 holds CS idle in bits 7:0, the loop count in bits 15:8 and the 10-bit packet length in bits 25:16. Bits 31:26 read as zero.
- R4: With command bit 15 clear, a write to word index 4 queues four bytes for the engine in the order bits 7:0, 15:8, 23:16, 31:24.
- R5: With command bit 15 set, a transmit word is queued most significant byte first.
- R6: The transmit FIFO holds FIFO_BYTES bytes. A transmit word written when fewer than four bytes are free is dropped entirely.
- R7: A read of word index 5 pops up to four received bytes. With command bit 14 clear the oldest byte is in bits 7:0. With it set, a full word has the oldest byte in bits 31:24. Bytes the engine offers while the receive FIFO is full are dropped.
- R8: A receive read with only k<4 bytes available returns them in the low k lanes and zeros above. With bit 14 set the oldest of the k bytes is in the highest of those lanes. A read of an empty FIFO returns zero.
- R9: Writing command bit 0 (start) or bit 1 (resume) gives a one-cycle pulse on the matching output in the cycle after the write. These bits read back as zero.
- R10: While command bit 2 is set, the engine hold output is high, both FIFOs are emptied, transmit writes, engine pushes and receive reads have no effect, and a start in the same write is suppressed.
- R11: An engine end event sets status bit 0, and sets bit 1 when the run ended paused. A status read (word index 7) returns this state and clears it, and the interrupt falls in the next cycle.
- R12: The interrupt is high while a normal end is pending and command bit 16 is set, or while a paused end is pending and command bit 17 is set.
- R13: When an end event and a status read fall in the same cycle, the new event stays pending.
- R14: Word indices 2 and 3 hold 32-bit memory addresses that drive outputs. Word index 9 keeps only bits 1:0 as the pad select. Other indices read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pop and clear side effects) |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sck_high_o | output | 8 | SCK high time |
| sck_low_o | output | 8 | SCK low time |
| cs_hold_o | output | 8 | CS hold time |
| cs_setup_o | output | 8 | CS setup time |
| cs_idle_o | output | 8 | CS idle time |
| loop_cnt_o | output | 8 | Packet loop count |
| pkt_len_o | output | 10 | Packet length |
| tx_src_o | output | 32 | Transmit memory address |
| rx_dst_o | output | 32 | Receive memory address |
| pad_sel_o | output | 2 | Pad select |
| cpha_o | output | 1 | Clock phase |
| cpol_o | output | 1 | Clock polarity |
| tx_msb_first_o | output | 1 | Transmit bit order |
| rx_msb_first_o | output | 1 | Receive bit order |
| pause_en_o | output | 1 | Pause mode enable |
| deassert_en_o | output | 1 | Deassert mode enable |
| start_o | output | 1 | Start strobe |
| resume_o | output | 1 | Resume strobe |
| eng_hold_o | output | 1 | Engine held in reset |
| tx_byte_rd | input | 1 | Engine takes the head transmit byte |
| tx_byte | output | 8 | Head transmit byte |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_byte_wr | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_full | output | 1 | Receive FIFO full |
| end_evt | input | 1 | Engine run ended (one cycle) |
| end_paused | input | 1 | The run ended in the paused state |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses the default FIFO_BYTES of 32. At this depth both FIFOs fill after only eight words or thirty-two engine bytes, so the full-FIFO drop on either side is reached in a few dozen cycles. The byte ordering of both ports is tested in both settings, with full and partly filled words. A scoreboard queue holds the expected transmit bytes in order. The status tests cover both kinds of end event under each interrupt enable, and also an event that arrives in the same cycle as a clearing read.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  localparam int LANES = 4;
  localparam int CNT_W = 3;

  // word indices on the register bus
  localparam logic [3:0] RG_CFG0  = 4'd0;
  localparam logic [3:0] RG_CFG1  = 4'd1;
  localparam logic [3:0] RG_TXADR = 4'd2;
  localparam logic [3:0] RG_RXADR = 4'd3;
  localparam logic [3:0] RG_TXD   = 4'd4;
  localparam logic [3:0] RG_RXD   = 4'd5;
  localparam logic [3:0] RG_CMD   = 4'd6;
  localparam logic [3:0] RG_STAT  = 4'd7;
  localparam logic [3:0] RG_PAD   = 4'd9;

  // command bit positions
  localparam int CB_START     = 0;
  localparam int CB_RESUME    = 1;
  localparam int CB_RESET     = 2;
  localparam int CB_PAUSE_EN  = 4;
  localparam int CB_DEASSERT  = 5;
  localparam int CB_CPHA      = 8;
  localparam int CB_CPOL      = 9;
  localparam int CB_TX_MSB    = 12;
  localparam int CB_RX_MSB    = 13;
  localparam int CB_RX_SWAP   = 14;
  localparam int CB_TX_SWAP   = 15;
  localparam int CB_FINISH_IE = 16;
  localparam int CB_PAUSE_IE  = 17;

  localparam logic [31:0] CMD_KEEP_MASK = 32'h0003_F334;
  localparam logic [31:0] CFG1_MASK     = 32'h03FF_FFFF;

  // Byte order for the transmit FIFO: result lane 0 is queued first.
  function automatic logic [31:0] tx_lane_order(input logic [31:0] w, input logic swap);
    return swap ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

  // Number of bytes one receive read takes from a FIFO holding lvl bytes.
  function automatic logic [CNT_W-1:0] rx_take(input int lvl);
    return (lvl >= LANES) ? CNT_W'(LANES) : CNT_W'(lvl);
  endfunction

  // Gather n valid head bytes (lane 0 oldest) into a word; zero above.
  function automatic logic [31:0] rx_pack(input logic [31:0] head,
                                          input logic [CNT_W-1:0] n,
                                          input logic swap);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(n)) begin
        if (swap) r[8*i +: 8] = head[8*(int'(n)-1-i) +: 8];
        else      r[8*i +: 8] = head[8*i +: 8];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_rf_byte_fifo.sv
// Byte FIFO with a multi-lane push side and a multi-lane peek/pop side.
// DEPTH must be a power of two; callers never exceed the free space or level.
module spi_rf_byte_fifo
  import spi_rf_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int IN_LANES  = 1,
  parameter int OUT_LANES = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic [CNT_W-1:0]           push_n,
  input  logic [IN_LANES*8-1:0]      push_data,
  input  logic [CNT_W-1:0]           pop_n,
  output logic [OUT_LANES*8-1:0]     peek_data,
  output logic [$clog2(DEPTH):0]     level
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < IN_LANES; i++) begin
      if (!flush && (i < int'(push_n)))
        mem[wr_ptr + AW'(i)] <= push_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      level  <= level + LW'(push_n) - LW'(pop_n);
    end
  end

  for (genvar j = 0; j < OUT_LANES; j++) begin : g_peek
    assign peek_data[8*j +: 8] = mem[rd_ptr + AW'(j)];
  end

endmodule

// File: rtl/spi_rf_cfg.sv
// Plain configuration storage: timing, packet shape, addresses, pad select.
module spi_rf_cfg
  import spi_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [3:0]  idx,
  input  logic [31:0] wdata,
  output logic [31:0] cfg0_q,
  output logic [31:0] cfg1_q,
  output logic [31:0] txadr_q,
  output logic [31:0] rxadr_q,
  output logic [1:0]  pad_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q  <= '0;
      cfg1_q  <= '0;
      txadr_q <= '0;
      rxadr_q <= '0;
      pad_q   <= '0;
    end else if (we) begin
      case (idx)
        RG_CFG0:  cfg0_q  <= wdata;
        RG_CFG1:  cfg1_q  <= wdata & CFG1_MASK;
        RG_TXADR: txadr_q <= wdata;
        RG_RXADR: rxadr_q <= wdata;
        RG_PAD:   pad_q   <= wdata[1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_rf_ctrl.sv
// Command register, start/resume strobes, read-to-clear status, interrupt.
module spi_rf_ctrl
  import spi_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        stat_rd,
  input  logic        end_evt,
  input  logic        end_paused,
  output logic [31:0] cmd_q,
  output logic        start_p,
  output logic        resume_p,
  output logic [1:0]  stat_q,
  output logic        irq
);

  logic launch_ok;
  assign launch_ok = cmd_we && !cmd_wdata[CB_RESET];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      start_p  <= 1'b0;
      resume_p <= 1'b0;
      stat_q   <= '0;
    end else begin
      start_p  <= launch_ok && cmd_wdata[CB_START];
      resume_p <= launch_ok && cmd_wdata[CB_RESUME];
      if (cmd_we) cmd_q <= cmd_wdata & CMD_KEEP_MASK;
      if (end_evt)      stat_q <= {end_paused, 1'b1};
      else if (stat_rd) stat_q <= 2'b00;
    end
  end

  assign irq = stat_q[0] && (stat_q[1] ? cmd_q[CB_PAUSE_IE] : cmd_q[CB_FINISH_IE]);

endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
  import spi_rf_pkg::*;
#(
  parameter int FIFO_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  sck_high_o,
  output logic [7:0]  sck_low_o,
  output logic [7:0]  cs_hold_o,
  output logic [7:0]  cs_setup_o,
  output logic [7:0]  cs_idle_o,
  output logic [7:0]  loop_cnt_o,
  output logic [9:0]  pkt_len_o,
  output logic [31:0] tx_src_o,
  output logic [31:0] rx_dst_o,
  output logic [1:0]  pad_sel_o,
  output logic        cpha_o,
  output logic        cpol_o,
  output logic        tx_msb_first_o,
  output logic        rx_msb_first_o,
  output logic        pause_en_o,
  output logic        deassert_en_o,
  output logic        start_o,
  output logic        resume_o,
  output logic        eng_hold_o,
  input  logic        tx_byte_rd,
  output logic [7:0]  tx_byte,
  output logic        tx_empty,
  input  logic        rx_byte_wr,
  input  logic [7:0]  rx_byte,
  output logic        rx_full,
  input  logic        end_evt,
  input  logic        end_paused,
  output logic        irq
);

  localparam int LW = $clog2(FIFO_BYTES) + 1;

  // named internal events
  logic          wr_txd, rd_rxd, wr_cmd, rd_stat;
  logic          tx_room, tx_push_ok, tx_pop_ok, rx_push_ok;
  logic [LW-1:0] tx_level, rx_level;
  logic [31:0]   cmd_q;
  logic [1:0]    stat_q;
  logic [31:0]   cfg0_q, cfg1_q, txadr_q, rxadr_q;
  logic [1:0]    pad_q;
  logic [CNT_W-1:0] tx_push_n, tx_pop_n, rx_push_n, rx_pop_n, rx_avail;
  logic [31:0]   rx_head;
  logic [31:0]   rx_word;

  assign wr_txd  = bus_wr && (bus_addr == RG_TXD);
  assign wr_cmd  = bus_wr && (bus_addr == RG_CMD);
  assign rd_rxd  = bus_rd && (bus_addr == RG_RXD);
  assign rd_stat = bus_rd && (bus_addr == RG_STAT);

  spi_rf_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_wr),
    .idx     (bus_addr),
    .wdata   (bus_wdata),
    .cfg0_q  (cfg0_q),
    .cfg1_q  (cfg1_q),
    .txadr_q (txadr_q),
    .rxadr_q (rxadr_q),
    .pad_q   (pad_q)
  );

  spi_rf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (wr_cmd),
    .cmd_wdata  (bus_wdata),
    .stat_rd    (rd_stat),
    .end_evt    (end_evt),
    .end_paused (end_paused),
    .cmd_q      (cmd_q),
    .start_p    (start_o),
    .resume_p   (resume_o),
    .stat_q     (stat_q),
    .irq        (irq)
  );

  assign eng_hold_o = cmd_q[CB_RESET];

  // transmit side: word in, one byte out per engine request
  assign tx_room    = (tx_level <= LW'(FIFO_BYTES - LANES));
  assign tx_push_ok = wr_txd && !eng_hold_o && tx_room;
  assign tx_pop_ok  = tx_byte_rd && !tx_empty && !eng_hold_o;
  assign tx_push_n  = tx_push_ok ? CNT_W'(LANES) : '0;
  assign tx_pop_n   = tx_pop_ok ? CNT_W'(1) : '0;

  spi_rf_byte_fifo #(
    .DEPTH     (FIFO_BYTES),
    .IN_LANES  (LANES),
    .OUT_LANES (1)
  ) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (eng_hold_o),
    .push_n    (tx_push_n),
    .push_data (tx_lane_order(bus_wdata, cmd_q[CB_TX_SWAP])),
    .pop_n     (tx_pop_n),
    .peek_data (tx_byte),
    .level     (tx_level)
  );

  assign tx_empty = (tx_level == '0);

  // receive side: one byte in per engine delivery, up to a word out per read
  assign rx_full    = (rx_level == LW'(FIFO_BYTES));
  assign rx_push_ok = rx_byte_wr && !rx_full && !eng_hold_o;
  assign rx_push_n  = rx_push_ok ? CNT_W'(1) : '0;
  assign rx_avail   = eng_hold_o ? '0 : rx_take(int'(rx_level));
  assign rx_pop_n   = rd_rxd ? rx_avail : '0;

  spi_rf_byte_fifo #(
    .DEPTH     (FIFO_BYTES),
    .IN_LANES  (1),
    .OUT_LANES (LANES)
  ) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (eng_hold_o),
    .push_n    (rx_push_n),
    .push_data (rx_byte),
    .pop_n     (rx_pop_n),
    .peek_data (rx_head),
    .level     (rx_level)
  );

  assign rx_word = rx_pack(rx_head, rx_avail, cmd_q[CB_RX_SWAP]);

  // read path
  always_comb begin
    case (bus_addr)
      RG_CFG0:  bus_rdata = cfg0_q;
      RG_CFG1:  bus_rdata = cfg1_q;
      RG_TXADR: bus_rdata = txadr_q;
      RG_RXADR: bus_rdata = rxadr_q;
      RG_RXD:   bus_rdata = rx_word;
      RG_CMD:   bus_rdata = cmd_q;
      RG_STAT:  bus_rdata = {30'd0, stat_q};
      RG_PAD:   bus_rdata = {30'd0, pad_q};
      default:  bus_rdata = '0;
    endcase
  end

  // field outputs
  assign sck_high_o     = cfg0_q[7:0];
  assign sck_low_o      = cfg0_q[15:8];
  assign cs_hold_o      = cfg0_q[23:16];
  assign cs_setup_o     = cfg0_q[31:24];
  assign cs_idle_o      = cfg1_q[7:0];
  assign loop_cnt_o     = cfg1_q[15:8];
  assign pkt_len_o      = cfg1_q[25:16];
  assign tx_src_o       = txadr_q;
  assign rx_dst_o       = rxadr_q;
  assign pad_sel_o      = pad_q;
  assign cpha_o         = cmd_q[CB_CPHA];
  assign cpol_o         = cmd_q[CB_CPOL];
  assign tx_msb_first_o = cmd_q[CB_TX_MSB];
  assign rx_msb_first_o = cmd_q[CB_RX_MSB];
  assign pause_en_o     = cmd_q[CB_PAUSE_EN];
  assign deassert_en_o  = cmd_q[CB_DEASSERT];

endmodule

// File: rtl/spi_rf_checker.sv
module spi_rf_checker #(
  parameter int FIFO_BYTES = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_wr,
  input logic                          bus_rd,
  input logic [3:0]                    bus_addr,
  input logic                          start_req,
  input logic                          start_o,
  input logic                          eng_hold,
  input logic                          irq,
  input logic                          end_evt,
  input logic                          finish_ie,
  input logic                          pause_ie,
  input logic [$clog2(FIFO_BYTES):0]   tx_level,
  input logic [$clog2(FIFO_BYTES):0]   rx_level
);

  localparam int LW = $clog2(FIFO_BYTES) + 1;

  // R6: transmit occupancy never passes the depth
  a_r6_tx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(FIFO_BYTES));

  // R9: a start pulse follows a command write carrying the start bit
  a_r9_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(bus_wr && bus_addr == 4'd6 && start_req));

  // R10: no start while the engine is held
  a_r10_hold_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_hold |-> !start_o);

  // R10: both FIFOs are empty one cycle into a hold
  a_r10_hold_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    eng_hold |=> (tx_level == '0 && rx_level == '0));

  // R11: a status read with no new event drops the interrupt
  a_r11_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'd7 && !end_evt) |=> !irq);

  // R11: the interrupt rises only after an end event or a command write
  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(end_evt || (bus_wr && bus_addr == 4'd6)));

  // R12: no interrupt with both enables clear
  a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (finish_ie || pause_ie));

endmodule

bind spi_reg_front spi_rf_checker #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .start_req (bus_wdata[0]),
  .start_o   (start_o),
  .eng_hold  (eng_hold_o),
  .irq       (irq),
  .end_evt   (end_evt),
  .finish_ie (cmd_q[16]),
  .pause_ie  (cmd_q[17]),
  .tx_level  (tx_level),
  .rx_level  (rx_level)
);

// File: tb/spi_reg_front_tb_top.sv
module spi_reg_front_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  sck_high_o, sck_low_o, cs_hold_o, cs_setup_o, cs_idle_o, loop_cnt_o;
  logic [9:0]  pkt_len_o;
  logic [31:0] tx_src_o, rx_dst_o;
  logic [1:0]  pad_sel_o;
  logic        cpha_o, cpol_o, tx_msb_first_o, rx_msb_first_o, pause_en_o, deassert_en_o;
  logic        start_o, resume_o, eng_hold_o;
  logic        tx_byte_rd, tx_empty, rx_byte_wr, rx_full, end_evt, end_paused, irq;
  logic [7:0]  tx_byte, rx_byte;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit drain_en = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  spi_reg_front dut_i (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_byte_wr = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_byte_wr = 1'b0;
  endtask

  task automatic end_event(input logic p);
    @(negedge clk);
    end_evt = 1'b1; end_paused = p;
    @(negedge clk);
    end_evt = 1'b0;
  endtask

  // driver: write a transmit word and queue the bytes the engine must see
  task automatic send_word(input logic [31:0] w, input bit swap, input bit expect_kept, input string tag);
    bus_write(4'd4, w);
    if (expect_kept) begin
      for (int i = 0; i < 4; i++) begin
        exp_q.push_back(swap ? w[8*(3-i) +: 8] : w[8*i +: 8]);
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic drain(input string tag);
    drain_en = 1'b1;
    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    drain_en = 1'b0;
    check({tag, " queue drained"}, exp_q.size(), 0);
    check({tag, " tx_empty after drain"}, tx_empty, 1);
  endtask

  // monitor: engine model takes transmit bytes and compares with the scoreboard
  initial begin
    tx_byte_rd = 1'b0;
    forever begin
      @(negedge clk);
      if (drain_en && !tx_empty && rst_n) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R6 unexpected tx byte got=%h exp=none", tx_byte);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (tx_byte !== e) begin
            failures++;
            $display("FAIL %s tx byte got=%h exp=%h", t, tx_byte, e);
          end
        end
        tx_byte_rd = 1'b1;
      end else begin
        tx_byte_rd = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rx_byte_wr = 0; rx_byte = 0; end_evt = 0; end_paused = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 tx_empty", tx_empty, 1);
    check("R1 hold", eng_hold_o, 0);
    check("R1 start", start_o, 0);
    bus_read(4'd7, d); check("R1 status", d, 0);
    bus_read(4'd6, d); check("R1 cmd", d, 0);
    bus_read(4'd0, d); check("R1 cfg0", d, 0);

    // R2 timing word
    bus_write(4'd0, 32'h4433_2211);
    check("R2 sck_high", sck_high_o, 8'h11);
    check("R2 sck_low", sck_low_o, 8'h22);
    check("R2 cs_hold", cs_hold_o, 8'h33);
    check("R2 cs_setup", cs_setup_o, 8'h44);
    bus_read(4'd0, d); check("R2 readback", d, 32'h4433_2211);

    // R3 packet word
    bus_write(4'd1, 32'hFFFF_FFFF);
    bus_read(4'd1, d); check("R3 upper bits zero", d, 32'h03FF_FFFF);
    bus_write(4'd1, 32'h0123_4567);
    check("R3 cs_idle", cs_idle_o, 8'h67);
    check("R3 loop", loop_cnt_o, 8'h45);
    check("R3 pkt_len", pkt_len_o, 10'h123);

    // R14 addresses, pad, reserved
    bus_write(4'd2, 32'h8000_1000);
    bus_write(4'd3, 32'h9000_2000);
    bus_write(4'd9, 32'hFFFF_FFFF);
    check("R14 tx_src", tx_src_o, 32'h8000_1000);
    check("R14 rx_dst", rx_dst_o, 32'h9000_2000);
    check("R14 pad", pad_sel_o, 2'd3);
    bus_read(4'd9, d); check("R14 pad readback", d, 32'd3);
    bus_read(4'd8, d); check("R14 reserved reads zero", d, 0);

    // R4 little-endian transmit
    send_word(32'hA3A2_A1A0, 1'b0, 1'b1, "R4");
    drain("R4");

    // R5 swapped transmit
    bus_write(4'd6, 32'h0000_8000);
    bus_read(4'd6, d); check("R5 cmd readback", d, 32'h0000_8000);
    send_word(32'hB3B2_B1B0, 1'b1, 1'b1, "R5");
    drain("R5");
    bus_write(4'd6, 32'h0);

    // R6 fill: the ninth word is dropped
    for (int k = 0; k < 9; k++)
      send_word(32'h0302_0100 + 32'(k) * 32'h0404_0404, 1'b0, k < 8, "R6");
    drain("R6");

    // R7 receive packing, both orders
    for (int i = 0; i < 4; i++) rx_push(8'h10 + 8'(i));
    bus_read(4'd5, d); check("R7 rx little", d, 32'h1312_1110);
    bus_write(4'd6, 32'h0000_4000);
    for (int i = 0; i < 4; i++) rx_push(8'h20 + 8'(i));
    bus_read(4'd5, d); check("R7 rx swapped", d, 32'h2021_2223);
    bus_write(4'd6, 32'h0);
    // R7 full receive FIFO drops extra bytes
    for (int i = 0; i < 32; i++) rx_push(8'h50 + 8'(i));
    check("R7 rx_full", rx_full, 1);
    rx_push(8'hEE);
    for (int k = 0; k < 8; k++) begin
      bus_read(4'd5, d);
      check("R7 rx word after full", d,
            {8'h53 + 8'(4*k), 8'h52 + 8'(4*k), 8'h51 + 8'(4*k), 8'h50 + 8'(4*k)});
    end
    bus_read(4'd5, d); check("R7 overflow byte dropped", d, 0);

    // R8 partial and empty reads
    for (int i = 0; i < 3; i++) rx_push(8'h31 + 8'(i));
    bus_read(4'd5, d); check("R8 partial little", d, 32'h0033_3231);
    bus_write(4'd6, 32'h0000_4000);
    rx_push(8'h41); rx_push(8'h42);
    bus_read(4'd5, d); check("R8 partial swapped", d, 32'h0000_4142);
    bus_read(4'd5, d); check("R8 empty read", d, 0);
    bus_write(4'd6, 32'h0);

    // R9 strobes
    bus_write(4'd6, 32'h1);
    check("R9 start pulse", start_o, 1);
    @(negedge clk);
    check("R9 start one cycle", start_o, 0);
    bus_read(4'd6, d); check("R9 start reads zero", d, 0);
    bus_write(4'd6, 32'h2);
    check("R9 resume pulse", resume_o, 1);
    check("R9 no start on resume", start_o, 0);
    @(negedge clk);
    check("R9 resume one cycle", resume_o, 0);

    // R10 soft reset
    bus_write(4'd4, 32'h1111_1111);
    bus_write(4'd4, 32'h2222_2222);
    rx_push(8'h61); rx_push(8'h62);
    bus_write(4'd6, 32'h5);
    check("R10 start suppressed", start_o, 0);
    check("R10 hold high", eng_hold_o, 1);
    @(negedge clk);
    check("R10 tx flushed", tx_empty, 1);
    bus_write(4'd4, 32'h3333_3333);
    rx_push(8'h63);
    bus_read(4'd5, d); check("R10 rx read held", d, 0);
    check("R10 tx write ignored", tx_empty, 1);
    bus_write(4'd6, 32'h0);
    check("R10 hold released", eng_hold_o, 0);
    check("R10 tx empty after", tx_empty, 1);
    bus_read(4'd5, d); check("R10 rx empty after", d, 0);

    // R11 status and interrupt
    bus_write(4'd6, 32'h0003_0000);
    end_event(1'b0);
    check("R11 irq on finish", irq, 1);
    bus_read(4'd7, d); check("R11 status finish", d, 32'h1);
    check("R11 irq cleared", irq, 0);
    bus_read(4'd7, d); check("R11 status cleared", d, 0);
    end_event(1'b1);
    check("R11 irq on pause", irq, 1);
    bus_read(4'd7, d); check("R11 status paused", d, 32'h3);
    check("R11 irq cleared after pause", irq, 0);

    // R12 enables
    bus_write(4'd6, 32'h0001_0000);
    end_event(1'b1);
    check("R12 pause masked", irq, 0);
    bus_read(4'd7, d); check("R12 status paused pending", d, 32'h3);
    bus_write(4'd6, 32'h0002_0000);
    end_event(1'b0);
    check("R12 finish masked", irq, 0);
    bus_read(4'd7, d); check("R12 status finish pending", d, 32'h1);
    end_event(1'b1);
    check("R12 pause enabled", irq, 1);
    bus_read(4'd7, d);

    // R13 event and clearing read in the same cycle
    bus_write(4'd6, 32'h0003_0000);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 4'd7; end_evt = 1'b1; end_paused = 1'b0;
    #1 d = bus_rdata;
    check("R13 read before event", d, 0);
    @(negedge clk);
    bus_rd = 1'b0; end_evt = 1'b0;
    check("R13 irq kept", irq, 1);
    bus_read(4'd7, d); check("R13 event kept", d, 32'h1);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule